// File: doc/BRIEF.md
# GCR Telemetry Edge Decoder

The block rebuilds a motor-controller telemetry reply from the times at which the reply line toggled. A capture unit outside the block timestamps each edge with a free-running 16-bit counter that runs at a power-of-two multiple of the reply bit rate, which is five quarters of the outgoing command bit rate. The block converts the spacing between edges into run lengths and builds a 21-bit run-length word. It maps the low twenty bits, five at a time, through a 5-to-4 group code table. It then checks the XOR nibble checksum and returns either the 12-bit payload with a valid flag or the fixed invalid code.

A capture opens with a one-cycle start pulse. The first timestamp after it only serves as the reference. Every later timestamp closes a run. An end strobe closes the capture and pads the last run to the frame length. The oversampling factor is given as a base-two logarithm, so each run length is found with a rounding add and a right shift. At most 21 timestamps are taken per capture. Reading the pin and interpreting the payload belong to other blocks.

Top module: `gcr_reply_decoder`

## Requirements
- R1: While reset is held and after it is released, done_o and payload_ok_o are 0 and payload_o is 0xFFF.
- R2: The first timestamp after start_i only sets the reference. Each later one yields a run length of (difference + 2^(s-1)) >> s, where s = spb_shift_i, 2^(s-1) counts as 0 when s is 0, and the difference is taken modulo 2^16. A difference up to half a bit period above or below a whole number of bit periods rounds to that whole number, including when the counter wraps.
- R3: For a run of length L, the word shifts left by L and bit L-1 is set. Bits [4:0], [9:5], [14:10] and [19:15] give nibbles 0 to 3 through the map 0x0F→15, 0x1E→12, 0x0E→14, 0x1D→4, 0x0D→13, 0x1B→1, 0x0B→11, 0x1A→8, 0x0A→10, 0x17→7, 0x09→9, 0x16→6, 0x15→5, 0x13→3, 0x12→2, with every other code giving 0. A good frame outputs nibbles 3..1 as payload_o and sets payload_ok_o to 1.
- R4: The XOR of the four nibbles must be 0xF. Otherwise payload_o is 0xFFF and payload_ok_o is 0.
- R5: If the bits gathered differ from 21 after padding, the result is invalid. This happens when a run takes the count past 21.
- R6: Once 21 bits have been gathered, further timestamps are ignored and no padding run is added.
- R7: An end strobe with no timestamp since start gives an invalid result.
- R8: A run that rounds to zero length makes the capture invalid.
- R9: done_o is high for exactly the one cycle after the clock edge that samples end_i. payload_o and payload_ok_o change only together with done_o.
- R10: end_i and edge_valid_i are ignored unless a capture is open. A capture closes at its end strobe. When start_i is high, an edge or end strobe in the same cycle is ignored.
- R11: A start_i during an open capture discards everything gathered so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new capture |
| edge_valid_i | input | 1 | edge_time_i carries an edge timestamp |
| edge_time_i | input | 16 | Counter value at the edge |
| end_i | input | 1 | Closes the capture and requests a result |
| spb_shift_i | input | 3 | log2 of counter ticks per reply bit |
| payload_o | output | 12 | Decoded payload, or 0xFFF when invalid |
| payload_ok_o | output | 1 | Result passed length and checksum tests |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench places timestamps exactly one tick inside the rounding window and across the 16-bit wrap. A design that truncates instead of rounding, or that subtracts without wrapping, returns a wrong payload there. It also sends a frame with a duplicated timestamp, a frame that overruns 21 bits, and a frame followed by extra edges once it is full. A decoder that skips zero runs, clamps the length, or keeps counting after the word is full reports the wrong validity in those cases. Further cases cover a valid payload of 0xFFF, whose flag must still be set, and an unmapped group code that must decode as zero. A restart in the middle of a capture and stray strobes while idle catch designs that keep stale state or pulse done_o without being armed.

// File: rtl/gcr_dec_pkg.sv
package gcr_dec_pkg;

    localparam int FRAME_BITS = 21;
    localparam int GROUP_W    = 5;
    localparam int NIB_W      = 4;
    localparam int GROUPS     = 4;
    localparam int WORD_W     = GROUPS * NIB_W;
    localparam int PAYLOAD_W  = WORD_W - NIB_W;
    localparam int LEN_W      = 6;
    localparam logic [PAYLOAD_W-1:0] INVALID_PAYLOAD = '1;
    localparam logic [NIB_W-1:0]     CSUM_GOOD       = '1;

    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [LEN_W-1:0]      len_t;
    typedef logic [WORD_W-1:0]     word_t;

    typedef struct packed {
        frame_t bits;
        logic   len_ok;
    } frame_res_t;

    function automatic logic [NIB_W-1:0] gcr_lookup(input logic [GROUP_W-1:0] code);
        case (code)
            5'h09: gcr_lookup = 4'd9;
            5'h0A: gcr_lookup = 4'd10;
            5'h0B: gcr_lookup = 4'd11;
            5'h0D: gcr_lookup = 4'd13;
            5'h0E: gcr_lookup = 4'd14;
            5'h0F: gcr_lookup = 4'd15;
            5'h12: gcr_lookup = 4'd2;
            5'h13: gcr_lookup = 4'd3;
            5'h15: gcr_lookup = 4'd5;
            5'h16: gcr_lookup = 4'd6;
            5'h17: gcr_lookup = 4'd7;
            5'h1A: gcr_lookup = 4'd8;
            5'h1B: gcr_lookup = 4'd1;
            5'h1D: gcr_lookup = 4'd4;
            5'h1E: gcr_lookup = 4'd12;
            default: gcr_lookup = 4'd0;
        endcase
    endfunction

    // Append one run: shift by the run length, mark the leading one.
    function automatic frame_t run_append(input frame_t v, input len_t l);
        frame_t sh;
        frame_t mk;
        if (l == '0) begin
            return v;
        end
        sh = (int'(l) >= FRAME_BITS) ? '0 : (v << l);
        mk = (int'(l) > FRAME_BITS)  ? '0 : (frame_t'(1) << (l - len_t'(1)));
        return sh | mk;
    endfunction

    function automatic len_t sat_add(input len_t a, input len_t b);
        logic [LEN_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[LEN_W] ? '1 : s[LEN_W-1:0];
    endfunction

    function automatic logic [NIB_W-1:0] nibble_fold(input word_t w);
        logic [NIB_W-1:0] acc;
        acc = '0;
        for (int g = 0; g < GROUPS; g++) begin
            acc ^= w[g*NIB_W +: NIB_W];
        end
        return acc;
    endfunction

endpackage

// File: rtl/gcr_run_collector.sv
module gcr_run_collector
    import gcr_dec_pkg::*;
#(
    parameter int TW        = 16,
    parameter int SW        = 3,
    parameter int MAX_EDGES = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          edge_valid_i,
    input  logic [TW-1:0] edge_time_i,
    input  logic          end_i,
    input  logic [SW-1:0] spb_shift_i,
    output logic          armed_o,
    output logic          fin_o,
    output frame_res_t    res_o
);

    localparam int CNT_W = $clog2(MAX_EDGES + 1);
    localparam logic [TW:0] LEN_SAT = (TW+1)'((1 << LEN_W) - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TW-1:0]    ref_q;
    frame_t           val_q;
    len_t             bits_q;
    logic             bad_q;

    logic [TW-1:0] diff_c;
    logic [TW:0]   half_c;
    logic [TW:0]   len_full_c;
    len_t          len_c;
    logic          take_c;
    logic          full_c;
    len_t          pad_c;

    always_comb begin
        diff_c     = edge_time_i - ref_q;
        half_c     = ({{TW{1'b0}}, 1'b1} << spb_shift_i) >> 1;
        len_full_c = ({1'b0, diff_c} + half_c) >> spb_shift_i;
        len_c      = (len_full_c > LEN_SAT) ? '1 : len_full_c[LEN_W-1:0];
        take_c     = armed_q && edge_valid_i && !start_i && !end_i
                     && (cnt_q < CNT_W'(MAX_EDGES));
        full_c     = (bits_q >= len_t'(FRAME_BITS));
        pad_c      = len_t'(FRAME_BITS) - bits_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            ref_q   <= '0;
            val_q   <= '0;
            bits_q  <= '0;
            bad_q   <= 1'b0;
        end else if (start_i) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
            val_q   <= '0;
            bits_q  <= '0;
            bad_q   <= 1'b0;
        end else if (armed_q && end_i) begin
            armed_q <= 1'b0;
        end else if (take_c) begin
            if (cnt_q == '0) begin
                ref_q <= edge_time_i;
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (!full_c) begin
                ref_q  <= edge_time_i;
                cnt_q  <= cnt_q + CNT_W'(1);
                val_q  <= run_append(val_q, len_c);
                bits_q <= sat_add(bits_q, len_c);
                if (len_c == '0) begin
                    bad_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        armed_o      = armed_q;
        fin_o        = armed_q && end_i && !start_i;
        res_o.bits   = (cnt_q != '0 && !full_c) ? run_append(val_q, pad_c) : val_q;
        res_o.len_ok = (cnt_q != '0) && !bad_q
                       && (!full_c || bits_q == len_t'(FRAME_BITS));
    end

    // R6: a full word is frozen against further edges
    p_frozen_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        (take_c && cnt_q != '0 && full_c) |=> ($stable(val_q) && $stable(bits_q)));

    // R8: a zero-length run poisons the capture
    p_zero_run_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (take_c && cnt_q != '0 && !full_c && len_c == '0) |=> bad_q);

    // R2: the reference edge adds no bits
    p_reference_only_r2: assert property (@(posedge clk) disable iff (rst)
        (take_c && cnt_q == '0) |=> (bits_q == '0 && val_q == '0));

endmodule

// File: rtl/gcr_word_check.sv
module gcr_word_check
    import gcr_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fin_i,
    input  frame_res_t           res_i,
    output logic [PAYLOAD_W-1:0] payload_o,
    output logic                 ok_o,
    output logic                 done_o
);

    word_t word_c;
    logic  ok_c;

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        assign word_c[g*NIB_W +: NIB_W] = gcr_lookup(res_i.bits[g*GROUP_W +: GROUP_W]);
    end

    assign ok_c = res_i.len_ok && (nibble_fold(word_c) == CSUM_GOOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            payload_o <= INVALID_PAYLOAD;
            ok_o      <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                ok_o      <= ok_c;
                payload_o <= ok_c ? word_c[WORD_W-1:NIB_W] : INVALID_PAYLOAD;
            end
        end
    end

    // R4: a rejected frame always carries the invalid code
    p_reject_code_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ok_o) |-> (payload_o == INVALID_PAYLOAD));

endmodule

// File: rtl/gcr_reply_decoder.sv
module gcr_reply_decoder
    import gcr_dec_pkg::*;
#(
    parameter int TW        = 16,
    parameter int SW        = 3,
    parameter int MAX_EDGES = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 edge_valid_i,
    input  logic [TW-1:0]        edge_time_i,
    input  logic                 end_i,
    input  logic [SW-1:0]        spb_shift_i,
    output logic [PAYLOAD_W-1:0] payload_o,
    output logic                 payload_ok_o,
    output logic                 done_o
);

    logic       armed;
    logic       fin;
    frame_res_t res;

    gcr_run_collector #(
        .TW(TW), .SW(SW), .MAX_EDGES(MAX_EDGES)
    ) i_collect (
        .clk(clk), .rst(rst), .start_i(start_i),
        .edge_valid_i(edge_valid_i), .edge_time_i(edge_time_i),
        .end_i(end_i), .spb_shift_i(spb_shift_i),
        .armed_o(armed), .fin_o(fin), .res_o(res)
    );

    gcr_word_check i_check (
        .clk(clk), .rst(rst), .fin_i(fin), .res_i(res),
        .payload_o(payload_o), .ok_o(payload_ok_o), .done_o(done_o)
    );

    // R9: result strobe lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: outputs hold between strobes
    p_result_held_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(payload_o) && $stable(payload_ok_o)));

    // R10: a strobe needs an open capture and an end request
    p_done_needs_capture_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(armed && end_i && !start_i));

endmodule

// File: tb/test_gcr_reply_decoder.sv
module test_gcr_reply_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        edge_valid_i = 1'b0;
    logic [15:0] edge_time_i = '0;
    logic        end_i = 1'b0;
    logic [2:0]  spb_shift_i = 3'd3;
    logic [11:0] payload_o;
    logic        payload_ok_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gcr_reply_decoder i_gcr_reply_decoder (
        .clk(clk), .rst(rst), .start_i(start_i),
        .edge_valid_i(edge_valid_i), .edge_time_i(edge_time_i),
        .end_i(end_i), .spb_shift_i(spb_shift_i),
        .payload_o(payload_o), .payload_ok_o(payload_ok_o), .done_o(done_o)
    );

    // {payload, corrupt, shift, jitter, first timestamp}
    localparam logic [39:0] VEC [8] = '{
        {12'h123, 1'b0, 3'd3, 8'd3,  16'h0100},
        {12'hFFF, 1'b0, 3'd2, 8'd1,  16'hFFF0},
        {12'h000, 1'b0, 3'd4, 8'd7,  16'hFF80},
        {12'hABC, 1'b1, 3'd3, 8'd0,  16'h0200},
        {12'h5A5, 1'b0, 3'd0, 8'd0,  16'h1234},
        {12'h7FE, 1'b0, 3'd5, 8'd15, 16'h0000},
        {12'h001, 1'b0, 3'd1, 8'd0,  16'h8000},
        {12'h800, 1'b1, 3'd2, 8'd1,  16'hFFFF}
    };

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'h19; 4'h1: enc = 5'h1B; 4'h2: enc = 5'h12; 4'h3: enc = 5'h13;
            4'h4: enc = 5'h1D; 4'h5: enc = 5'h15; 4'h6: enc = 5'h16; 4'h7: enc = 5'h17;
            4'h8: enc = 5'h1A; 4'h9: enc = 5'h09; 4'hA: enc = 5'h0A; 4'hB: enc = 5'h0B;
            4'hC: enc = 5'h1E; 4'hD: enc = 5'h0D; 4'hE: enc = 5'h0E; default: enc = 5'h0F;
        endcase
    endfunction

    function automatic logic [20:0] build(input logic [11:0] p, input logic corrupt);
        logic [3:0] n0;
        n0 = ~(p[11:8] ^ p[7:4] ^ p[3:0]) ^ {3'b000, corrupt};
        return {1'b1, enc(p[11:8]), enc(p[7:4]), enc(p[3:0]), enc(n0)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_edge(input logic [15:0] t);
        edge_valid_i = 1'b1;
        edge_time_i  = t;
        @(negedge clk);
        edge_valid_i = 1'b0;
    endtask

    task automatic pulse_end();
        end_i = 1'b1;
        @(negedge clk);
        end_i = 1'b0;
    endtask

    // Sends the edges of a 21-bit run-length word; dup repeats the third edge.
    task automatic send_word(input logic [20:0] v, input logic [15:0] t0,
                             input logic [7:0] jit, input bit dup);
        int k = 0;
        for (int i = 20; i >= 0; i--) begin
            if (v[i]) begin
                logic [15:0] t;
                t = t0 + (16'(20 - i) << spb_shift_i) + ((k % 2 == 1) ? 16'(jit) : 16'd0);
                pulse_edge(t);
                if (dup && k == 2) pulse_edge(t);
                k++;
            end
        end
    endtask

    task automatic expect_result(input string req, input logic [11:0] pay, input logic ok);
        chk(done_o === 1'b1, req, int'(done_o), 1);
        chk(payload_o === pay, req, int'(payload_o), int'(pay));
        chk(payload_ok_o === ok, req, int'(payload_ok_o), int'(ok));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] pay;
        logic [12:0] snap;
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        chk(done_o === 1'b0 && payload_ok_o === 1'b0, "R1", int'({done_o, payload_ok_o}), 0);
        chk(payload_o === 12'hFFF, "R1", int'(payload_o), 'hFFF);
        rst = 1'b0;
        @(negedge clk);
        chk(done_o === 1'b0 && payload_o === 12'hFFF, "R1", int'(payload_o), 'hFFF);

        // Table walk: R2 rounding and wrap, R3 decode, R4 checksum
        for (int n = 0; n < 8; n++) begin
            logic [39:0] e;
            e = VEC[n];
            spb_shift_i = e[26:24];
            pulse_start();
            send_word(build(e[39:28], e[27]), e[15:0], e[23:16], 1'b0);
            pulse_end();
            if (e[27]) expect_result("R4", 12'hFFF, 1'b0);
            else       expect_result("R3", e[39:28], 1'b1);
        end

        // R9: strobe lasts one cycle and the result holds
        snap = {payload_o, payload_ok_o};
        @(negedge clk);
        chk(done_o === 1'b0, "R9", int'(done_o), 0);
        chk({payload_o, payload_ok_o} === snap, "R9", int'({payload_o, payload_ok_o}), int'(snap));

        // R3: an unmapped group code decodes as 0
        spb_shift_i = 3'd3;
        pulse_start();
        send_word({1'b1, 5'h19, 5'h19, 5'h1C, 5'h0F}, 16'h0040, 8'd2, 1'b0);
        pulse_end();
        expect_result("R3", 12'h000, 1'b1);

        // R5: a run that overruns the frame length
        pulse_start();
        pulse_edge(16'h0000);
        pulse_edge(16'd22 << 3);
        pulse_end();
        expect_result("R5", 12'hFFF, 1'b0);

        // R6: edges after the word is full are ignored, no padding run is added
        pay = 12'h3C6;
        pulse_start();
        send_word(build(pay, 1'b0), 16'h0500, 8'd0, 1'b0);
        pulse_edge(16'h0500 + (16'd21 << 3));
        pulse_edge(16'h0500 + (16'd24 << 3));
        pulse_end();
        expect_result("R6", pay, 1'b1);

        // R7: end with no timestamps
        pulse_start();
        pulse_end();
        expect_result("R7", 12'hFFF, 1'b0);

        // R8: a duplicated timestamp gives a zero run
        pulse_start();
        send_word(build(12'h456, 1'b0), 16'h0900, 8'd0, 1'b1);
        pulse_end();
        expect_result("R8", 12'hFFF, 1'b0);

        // R10: strobes while idle are ignored
        pulse_edge(16'h0001);
        pulse_end();
        chk(done_o === 1'b0, "R10", int'(done_o), 0);
        chk(payload_o === 12'hFFF, "R10", int'(payload_o), 'hFFF);

        // R11: restart discards a partial capture
        pulse_start();
        pulse_edge(16'h0000);
        pulse_edge(16'd3 << 3);
        pulse_edge(16'd9 << 3);
        pulse_start();
        send_word(build(12'h9D2, 1'b0), 16'h7770, 8'd3, 1'b0);
        pulse_end();
        expect_result("R11", 12'h9D2, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule